// File: doc/BRIEF.md
# Region Protection Checker

This block judges every memory access against eight programmable protection regions and gives its verdict in the same cycle as the access. It translates nothing: the address only selects which region's rules apply. Instruction fetches and data accesses share the one region set. Each access carries three attribute flags: fetch or data, write or read, and privileged or user. The block answers with allow, fault and the index of the region that decided.

Software sets the regions through a small register-write port. Each region holds a base address, a size written as log2 of the byte count (32 bytes up to the whole 4 GB space), an enable, a permission code and an execute-never bit. A control register switches the whole unit on or off. When several enabled regions cover an address, the highest-numbered one wins. An enabled unit with no covering region lets privileged accesses through and faults user accesses.

Top module: `prot_region_guard`

## Requirements
- R1: After reset the unit is off and every region is disabled, so any access gives acc_allow=1, acc_fault=0, hit_valid=0 and hit_idx=0.
- R2: While the unit is off, every access is allowed and hit_valid stays 0, whatever the regions hold.
- R3: The verdict and hit outputs are combinational in the access inputs and the stored registers. They change in the same cycle as the access, with no clock edge needed.
- R4: Region i covers an address when the region is enabled and the address bits at and above position k equal the same bits of the base, where k is the stored size code. Base bits below k are ignored. A size code of 32 covers every address. A written size code below 5 is stored as 5 and one above 32 is stored as 32.
- R5: When more than one enabled region covers the address, the highest index decides and is reported on hit_idx with hit_valid=1. With no covering region, hit_idx is 0.
- R6: Permission codes: 0 faults every access; 1 allows privileged reads and writes and faults all user accesses; 2 allows privileged reads and writes and user reads but faults user writes; 3 allows everything. acc_fault is always the inverse of acc_allow.
- R7: When the execute-never bit of the deciding region is set, an instruction fetch faults. Data reads and writes are still judged by the permission code alone.
- R8: With the unit on and no covering region, a privileged access is allowed and a user access faults.
- R9: A fetch is judged against the same regions as a data access and counts as a read: its write flag is ignored.
- R10: Register writes take effect at the next rising clock edge. reg_addr 0 is control (bit 0 turns the unit on). reg_addr with its top bit set addresses region reg_addr[3:1]: bit 0 clear writes the 32-bit base; bit 0 set writes the attributes (bits 5:0 size code, bit 6 enable, bits 8:7 permission code, bit 9 execute-never). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (control or region base/attributes) |
| reg_wdata | input | 32 | Register write data |
| acc_addr | input | 32 | Access address |
| acc_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_priv | input | 1 | 1 for privileged, 0 for user |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access refused |
| hit_valid | output | 1 | An enabled region covers the address and the unit is on |
| hit_idx | output | 3 | Index of the deciding region |

## Verification
The verdict, hit_valid and hit_idx are due in the same cycle as the access. The bench therefore drives the access flags at a falling edge and samples the outputs one time unit later, before any rising edge can occur. A register write lands at the first rising edge after it is driven. The bench drives each write at a falling edge, waits until the next falling edge so that exactly one rising edge has passed, and only then updates its own copy of the regions. Every later comparison then reflects the stored state.

// File: rtl/prot_pkg.sv
package prot_pkg;

  localparam int ADDR_W  = 32;
  localparam int SZ_W    = 6;
  localparam int MIN_LOG = 5;
  localparam int MAX_LOG = ADDR_W;

  typedef enum logic [1:0] {
    PERM_NONE       = 2'd0,
    PERM_PRIV_RW    = 2'd1,
    PERM_PRIV_USRRO = 2'd2,
    PERM_FULL       = 2'd3
  } perm_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [SZ_W-1:0]   size_log;
    logic              on;
    perm_e             perm;
    logic              xn;
  } region_t;

  // Bound a written size code into the legal range.
  function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] k);
    if (k < SZ_W'(MIN_LOG)) return SZ_W'(MIN_LOG);
    if (k > SZ_W'(MAX_LOG)) return SZ_W'(MAX_LOG);
    return k;
  endfunction

  // Address lies inside an aligned power-of-two window.
  function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b,
                                      input logic [SZ_W-1:0]   k);
    logic [ADDR_W-1:0] keep;
    if (k >= SZ_W'(MAX_LOG)) return 1'b1;
    keep = {ADDR_W{1'b1}} << k;
    return ((a ^ b) & keep) == '0;
  endfunction

  // Permission verdict for one region.
  function automatic logic access_ok(input perm_e p, input logic xn,
                                     input logic priv, input logic write,
                                     input logic fetch);
    logic wr;
    if (fetch && xn) return 1'b0;
    wr = write && !fetch;
    case (p)
      PERM_NONE:       return 1'b0;
      PERM_PRIV_RW:    return priv;
      PERM_PRIV_USRRO: return priv || !wr;
      default:         return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/prot_region_file.sv
module prot_region_file
  import prot_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [$clog2(NREG)+1:0] reg_addr,
  input  logic [ADDR_W-1:0]       reg_wdata,
  output region_t [NREG-1:0]      regs,
  output logic                    unit_en
);
  localparam int IDX_W = $clog2(NREG);
  localparam int RA_W  = IDX_W + 2;

  logic             region_space;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_attr;
  logic             ctl_hit;

  assign region_space = reg_addr[RA_W-1];
  assign wr_idx       = reg_addr[RA_W-2:1];
  assign wr_attr      = reg_addr[0];
  assign ctl_hit      = reg_we && (reg_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unit_en <= 1'b0;
    else if (ctl_hit) unit_en <= reg_wdata[0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_region
    region_t r_q;
    logic    sel;
    assign sel = reg_we && region_space && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q.base     <= '0;
        r_q.size_log <= SZ_W'(MIN_LOG);
        r_q.on       <= 1'b0;
        r_q.perm     <= PERM_NONE;
        r_q.xn       <= 1'b0;
      end else if (sel) begin
        if (wr_attr) begin
          r_q.size_log <= clamp_size(reg_wdata[SZ_W-1:0]);
          r_q.on       <= reg_wdata[6];
          r_q.perm     <= perm_e'(reg_wdata[8:7]);
          r_q.xn       <= reg_wdata[9];
        end else begin
          r_q.base <= reg_wdata;
        end
      end
    end

    assign regs[g] = r_q;
  end

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
  import prot_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  region_t [NREG-1:0] regs,
  output logic [NREG-1:0]    hit_vec
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit_vec[g] = regs[g].on && region_hit(addr, regs[g].base, regs[g].size_log);
  end
endmodule

// File: rtl/prot_prio_pick.sv
module prot_prio_pick #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]         hit_vec,
  output logic                    any_hit,
  output logic [$clog2(NREG)-1:0] top_idx
);
  localparam int IDX_W = $clog2(NREG);

  always_comb begin
    any_hit = 1'b0;
    top_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        top_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prot_region_guard.sv
module prot_region_guard
  import prot_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [$clog2(NREG)+1:0] reg_addr,
  input  logic [31:0]             reg_wdata,
  input  logic [31:0]             acc_addr,
  input  logic                    acc_fetch,
  input  logic                    acc_write,
  input  logic                    acc_priv,
  output logic                    acc_allow,
  output logic                    acc_fault,
  output logic                    hit_valid,
  output logic [$clog2(NREG)-1:0] hit_idx
);
  localparam int IDX_W = $clog2(NREG);

  region_t [NREG-1:0] regs;
  logic               unit_en;
  logic [NREG-1:0]    hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   top_idx;
  region_t            sel_region;
  logic               sel_xn;
  logic               region_ok;

  prot_region_file #(.NREG(NREG)) u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .regs      (regs),
    .unit_en   (unit_en)
  );

  prot_region_match #(.NREG(NREG)) u_match (
    .addr    (acc_addr),
    .regs    (regs),
    .hit_vec (hit_vec)
  );

  prot_prio_pick #(.NREG(NREG)) u_pick (
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .top_idx (top_idx)
  );

  assign sel_region = regs[top_idx];
  assign sel_xn     = sel_region.xn;
  assign region_ok  = access_ok(sel_region.perm, sel_region.xn,
                                acc_priv, acc_write, acc_fetch);

  always_comb begin
    if (!unit_en) begin
      acc_allow = 1'b1;
      hit_valid = 1'b0;
      hit_idx   = '0;
    end else if (any_hit) begin
      acc_allow = region_ok;
      hit_valid = 1'b1;
      hit_idx   = top_idx;
    end else begin
      acc_allow = acc_priv;
      hit_valid = 1'b0;
      hit_idx   = '0;
    end
  end

  assign acc_fault = ~acc_allow;

endmodule

// File: rtl/prot_region_check_sva.sv
module prot_region_check_sva #(
  parameter int NREG = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [$clog2(NREG)+1:0] reg_addr,
  input logic [31:0]             reg_wdata,
  input logic                    acc_fetch,
  input logic                    acc_priv,
  input logic                    acc_allow,
  input logic                    acc_fault,
  input logic                    hit_valid,
  input logic [$clog2(NREG)-1:0] hit_idx,
  input logic                    unit_en,
  input logic [NREG-1:0]         hit_vec,
  input logic                    sel_xn
);

  assert_verdict_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_allow != acc_fault);

  assert_off_allows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |-> (acc_allow && !hit_valid));

  assert_nomatch_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && hit_vec == '0) |-> ((acc_allow == acc_priv) && !hit_valid && hit_idx == '0));

  assert_xn_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && hit_valid && sel_xn && acc_fetch) |-> acc_fault);

  assert_top_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ((hit_vec >> hit_idx) == NREG'(1)));

  assert_ctl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> (unit_en == $past(reg_wdata[0])));

endmodule

bind prot_region_guard prot_region_check_sva #(.NREG(NREG)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .acc_fetch (acc_fetch),
  .acc_priv  (acc_priv),
  .acc_allow (acc_allow),
  .acc_fault (acc_fault),
  .hit_valid (hit_valid),
  .hit_idx   (hit_idx),
  .unit_en   (unit_en),
  .hit_vec   (hit_vec),
  .sel_xn    (sel_xn)
);

// File: tb/test_prot_region_guard.sv
module test_prot_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_fetch = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_priv = 1'b0;
  logic        acc_allow, acc_fault, hit_valid;
  logic [2:0]  hit_idx;

  int checks = 0;
  int errors = 0;

  // bench copy of the programmed state
  bit          m_unit;
  logic [31:0] m_base [NREG];
  int          m_size [NREG];
  bit          m_on   [NREG];
  int          m_perm [NREG];
  bit          m_xn   [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_region_guard #(.NREG(NREG)) i_prot_region_guard (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .acc_addr(acc_addr), .acc_fetch(acc_fetch),
    .acc_write(acc_write), .acc_priv(acc_priv), .acc_allow(acc_allow),
    .acc_fault(acc_fault), .hit_valid(hit_valid), .hit_idx(hit_idx)
  );

  function automatic int eff_log(int k);
    if (k < 5) return 5;
    if (k > 32) return 32;
    return k;
  endfunction

  function automatic bit m_hit(int i, logic [31:0] a);
    int k;
    if (!m_on[i]) return 0;
    k = m_size[i];
    if (k >= 32) return 1;
    return (a >> k) == (m_base[i] >> k);
  endfunction

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 5'd0) m_unit = d[0];
    else if (a[4]) begin
      if (a[0]) begin
        m_size[a[3:1]] = eff_log(int'(d[5:0]));
        m_on[a[3:1]]   = d[6];
        m_perm[a[3:1]] = int'(d[8:7]);
        m_xn[a[3:1]]   = d[9];
      end else m_base[a[3:1]] = d;
    end
  endtask

  task automatic set_region(int i, logic [31:0] base, int sz, bit on, int perm, bit xn);
    logic [31:0] attr;
    attr = 32'(sz & 63) | (32'(on) << 6) | (32'(perm & 3) << 7) | (32'(xn) << 9);
    wr_reg({1'b1, 3'(i), 1'b0}, base);
    wr_reg({1'b1, 3'(i), 1'b1}, attr);
  endtask

  task automatic probe(logic [31:0] a, bit f, bit w, bit p, string tag);
    bit e_allow, e_valid, ok;
    int e_idx;
    @(negedge clk);
    acc_addr = a; acc_fetch = f; acc_write = w; acc_priv = p;
    #1;
    e_valid = 0; e_idx = 0;
    if (!m_unit) e_allow = 1;
    else begin
      for (int i = 0; i < NREG; i++) if (m_hit(i, a)) begin e_valid = 1; e_idx = i; end
      if (!e_valid) e_allow = p;
      else if (f && m_xn[e_idx]) e_allow = 0;
      else if (m_perm[e_idx] == 0) e_allow = 0;
      else if (m_perm[e_idx] == 3) e_allow = 1;
      else if (p) e_allow = 1;
      else e_allow = (m_perm[e_idx] == 2) && (f || !w);
    end
    checks++;
    ok = (acc_allow == e_allow) && (acc_fault == !e_allow) &&
         (hit_valid == e_valid) && (int'(hit_idx) == e_idx);
    if (!ok) begin
      errors++;
      $display("FAIL %s addr=%h: allow/fault/valid/idx actual %0b/%0b/%0b/%0d expected %0b/%0b/%0b/%0d",
               tag, a, acc_allow, acc_fault, hit_valid, hit_idx,
               e_allow, !e_allow, e_valid, e_idx);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_unit = 0;
    for (int i = 0; i < NREG; i++) begin
      m_base[i] = '0; m_size[i] = 5; m_on[i] = 0; m_perm[i] = 0; m_xn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe(32'h1234_5678, 0, 1, 0, "R1 reset");
    // R2 unit off ignores an enabled no-access region
    set_region(0, 32'h0000_0000, 32, 1, 0, 0);
    probe(32'h0000_1000, 0, 1, 0, "R2 unit off");
    set_region(0, 32'h0000_0000, 32, 0, 3, 0);
    // R10 control write turns unit on; R8 default map
    wr_reg(5'd0, 32'h1);
    probe(32'h7000_0000, 0, 0, 1, "R8 priv no match");
    probe(32'h7000_0000, 0, 0, 0, "R8 user no match");
    // R10 unused address ignored: unit still on, user still faults
    wr_reg(5'd1, 32'h0);
    probe(32'h7000_0000, 0, 0, 0, "R10 unused address");
    // R4 32-byte window edges
    set_region(1, 32'h2000_0040, 5, 1, 3, 0);
    probe(32'h2000_005F, 0, 1, 0, "R4 top byte");
    probe(32'h2000_0060, 0, 1, 0, "R4 past end");
    probe(32'h2000_003F, 0, 1, 0, "R4 before base");
    // R4 size code below minimum clamps to 32 bytes, low base bits ignored
    set_region(2, 32'h3000_0007, 2, 1, 3, 0);
    probe(32'h3000_001C, 0, 0, 0, "R4 clamp inside");
    probe(32'h3000_0020, 0, 0, 0, "R4 clamp outside");
    // R4 full space and oversize code
    set_region(0, 32'hDEAD_BEEF, 40, 1, 3, 0);
    probe(32'hFFFF_FFFC, 0, 1, 0, "R4 whole space");
    // R5 overlap: region 3 beats regions 0 and 1
    set_region(3, 32'h2000_0000, 12, 1, 1, 0);
    probe(32'h2000_0050, 0, 1, 0, "R5 highest index user");
    probe(32'h2000_0050, 0, 1, 1, "R5 highest index priv");
    // R6 permission codes
    set_region(4, 32'h4000_0000, 16, 1, 2, 0);
    probe(32'h4000_1234, 0, 0, 0, "R6 user read ro");
    probe(32'h4000_1234, 0, 1, 0, "R6 user write ro");
    probe(32'h4000_1234, 0, 1, 1, "R6 priv write ro");
    set_region(5, 32'h5000_0000, 10, 1, 0, 0);
    probe(32'h5000_0100, 0, 0, 1, "R6 none priv read");
    // R7 execute-never
    set_region(6, 32'h6000_0000, 20, 1, 3, 1);
    probe(32'h6000_0400, 1, 0, 1, "R7 fetch xn");
    probe(32'h6000_0400, 0, 1, 0, "R7 data in xn region");
    // R9 fetch uses the same regions and ignores its write flag
    probe(32'h4000_0010, 1, 1, 0, "R9 user fetch ro region");
    probe(32'h2000_0050, 1, 0, 0, "R9 user fetch priv region");
    // R3 address change alone, no clock edge, moves the verdict
    probe(32'h5000_0100, 0, 0, 0, "R3 same cycle");
    // R10 region disable falls back to lower region
    set_region(5, 32'h5000_0000, 10, 0, 0, 0);
    probe(32'h5000_0100, 0, 0, 0, "R10 region disabled");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      int r;
      if (n % 25 == 0) begin
        r = int'($urandom_range(0, NREG - 1));
        set_region(r, $urandom, int'($urandom_range(3, 34)),
                   bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
                   bit'($urandom_range(0, 1)));
      end
      if (n == 300) wr_reg(5'd0, 32'h0);
      if (n == 400) wr_reg(5'd0, 32'h1);
      r = int'($urandom_range(0, NREG - 1));
      if ($urandom_range(0, 1) == 1) a = m_base[r] ^ ($urandom & 32'h0000_0FFF);
      else a = $urandom;
      probe(a, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), "R4 R5 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule